// File: doc/BRIEF.md
# Partitioned SIMD Signed Compare Unit

This unit compares two 64-bit operands lane by lane, treating each operand as packed two's-complement integers. A 9-bit operation code picks the lane size and the relation. With 16-bit lanes each operand holds four lanes; with 32-bit lanes it holds two. The relation is one of greater-than, equal, less-or-equal or not-equal. Each lane of the first operand stands on the left of the relation and the matching lane of the second operand stands on the right.

The outcome is one predicate bit per lane. The bits are packed into the low end of a zero-extended 64-bit word, which is meant for an integer destination register. Codes outside the eight defined operations produce a zero word and raise an illegal flag. A low enable does the same. With the default configuration a single output stage captures the word on a valid strobe, one cycle after the strobe.

Top module: `simd_lane_cmp`

## Requirements
- R1: In 16-bit mode each operand splits into four signed lanes, with lane k at bits 16k+15:16k, so lane 0 is bits 15:0. Result bit k is 1 exactly when lane k of `src_a` satisfies the selected relation against lane k of `src_b`.
- R2: In 32-bit mode each operand splits into two signed lanes, lane 0 at bits 31:0 and lane 1 at bits 63:32. Result bits 0 and 1 hold the outcomes for lanes 0 and 1.
- R3: Result bits above the lane count are always 0: bits 63:4 in 16-bit mode and bits 63:2 in 32-bit mode.
- R4: The relation is evaluated as `src_a` REL `src_b`, never the reverse. For example, greater-than on lane values a=1, b=0 gives 1, and a=0, b=1 gives 0.
- R5: Operation codes (hex): 020 = less-or-equal/16, 022 = not-equal/16, 024 = less-or-equal/32, 026 = not-equal/32, 028 = greater-than/16, 02A = equal/16, 02C = greater-than/32, 02E = equal/32.
- R6: Any other value of `opcode` gives a zero result with `illegal` = 1. A legal code gives `illegal` = 0 while `en` is high.
- R7: While `en` is low, the result is zero and `illegal` is 1, whatever the operation code and operands.
- R8: With `REGISTERED` = 1, the result and the illegal flag appear on the outputs in the cycle after `valid_in` is sampled high, and `valid_out` pulses in that same cycle. When `valid_in` is low, `result` and `illegal` hold their values.
- R9: A synchronous active-high `rst` clears `result`, `illegal` and `valid_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Unit enable; low forces a zero result and flags illegal |
| valid_in | input | 1 | Strobe that captures the current comparison |
| opcode | input | 9 | Operation code selecting the relation and lane size |
| src_a | input | 64 | First operand, on the left of the relation |
| src_b | input | 64 | Second operand, on the right of the relation |
| result | output | 64 | Zero-extended per-lane predicate mask |
| illegal | output | 1 | Unknown operation code or unit disabled |
| valid_out | output | 1 | Result captured in the previous cycle |

## Verification
The cases most easily missed are lanes that sit at the signed extremes, where 0x8000 must compare below 0x7FFF, and lanes whose outcome flips when the operands swap sides. A swept operand pool rotates the most negative, minus one, zero, one and most positive values through every lane. The two operands draw from the pool at different strides, so equal, greater and smaller lanes occur together in one word. The whole 9-bit code space is also swept against these pools, which reaches the illegal codes that lie next to the eight legal ones.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    localparam int OPC_W = 9;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_EQ = 2'd1,
        REL_LE = 2'd2,
        REL_NE = 2'd3
    } cmp_rel_e;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic       legal;
        cmp_rel_e   rel;
        lane_mode_e mode;
    } cmp_ctrl_t;

    localparam logic [OPC_W-1:0] OPC_LE_N = 9'h020;
    localparam logic [OPC_W-1:0] OPC_NE_N = 9'h022;
    localparam logic [OPC_W-1:0] OPC_LE_W = 9'h024;
    localparam logic [OPC_W-1:0] OPC_NE_W = 9'h026;
    localparam logic [OPC_W-1:0] OPC_GT_N = 9'h028;
    localparam logic [OPC_W-1:0] OPC_EQ_N = 9'h02A;
    localparam logic [OPC_W-1:0] OPC_GT_W = 9'h02C;
    localparam logic [OPC_W-1:0] OPC_EQ_W = 9'h02E;

    function automatic cmp_ctrl_t decode_opc(input logic [OPC_W-1:0] opc);
        cmp_ctrl_t c;
        c.legal = 1'b1;
        c.rel   = REL_GT;
        c.mode  = MODE_NARROW;
        case (opc)
            OPC_LE_N: begin c.rel = REL_LE; c.mode = MODE_NARROW; end
            OPC_NE_N: begin c.rel = REL_NE; c.mode = MODE_NARROW; end
            OPC_LE_W: begin c.rel = REL_LE; c.mode = MODE_WIDE;   end
            OPC_NE_W: begin c.rel = REL_NE; c.mode = MODE_WIDE;   end
            OPC_GT_N: begin c.rel = REL_GT; c.mode = MODE_NARROW; end
            OPC_EQ_N: begin c.rel = REL_EQ; c.mode = MODE_NARROW; end
            OPC_GT_W: begin c.rel = REL_GT; c.mode = MODE_WIDE;   end
            OPC_EQ_W: begin c.rel = REL_EQ; c.mode = MODE_WIDE;   end
            default:  c.legal = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic apply_rel(input cmp_rel_e rel, input logic gt, input logic eq);
        logic r;
        case (rel)
            REL_GT:  r = gt;
            REL_EQ:  r = eq;
            REL_LE:  r = ~gt;
            default: r = ~eq;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/simd_cmp_decode.sv
module simd_cmp_decode
    import simd_cmp_pkg::*;
(
    input  logic             en,
    input  logic [OPC_W-1:0] opcode,
    output cmp_ctrl_t        ctrl
);

    cmp_ctrl_t raw;

    always_comb begin
        raw        = decode_opc(opcode);
        ctrl       = raw;
        ctrl.legal = raw.legal & en;
    end

endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [LANES-1:0]  gt,
    output logic [LANES-1:0]  eq
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [LANE_W-1:0] la;
        logic signed [LANE_W-1:0] lb;
        assign la    = opa[k*LANE_W +: LANE_W];
        assign lb    = opb[k*LANE_W +: LANE_W];
        assign gt[k] = (la > lb);
        assign eq[k] = (la == lb);
    end

endmodule

// File: rtl/simd_cmp_pack.sv
module simd_cmp_pack
    import simd_cmp_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int N_NARROW = 4,
    parameter int N_WIDE   = 2
) (
    input  cmp_ctrl_t           ctrl,
    input  logic [N_NARROW-1:0] gt_n,
    input  logic [N_NARROW-1:0] eq_n,
    input  logic [N_WIDE-1:0]   gt_w,
    input  logic [N_WIDE-1:0]   eq_w,
    output logic [DATA_W-1:0]   res
);

    always_comb begin
        res = '0;
        if (ctrl.legal) begin
            if (ctrl.mode == MODE_NARROW) begin
                for (int k = 0; k < N_NARROW; k++) begin
                    res[k] = apply_rel(ctrl.rel, gt_n[k], eq_n[k]);
                end
            end else begin
                for (int k = 0; k < N_WIDE; k++) begin
                    res[k] = apply_rel(ctrl.rel, gt_w[k], eq_w[k]);
                end
            end
        end
    end

endmodule

// File: rtl/simd_cmp_out.sv
module simd_cmp_out #(
    parameter int DATA_W     = 64,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] res_d,
    input  logic              illegal_d,
    output logic [DATA_W-1:0] result,
    output logic              illegal,
    output logic              valid_out
);

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                result    <= '0;
                illegal   <= 1'b0;
                valid_out <= 1'b0;
            end else begin
                valid_out <= valid_in;
                if (valid_in) begin
                    result  <= res_d;
                    illegal <= illegal_d;
                end
            end
        end
    end else begin : g_comb
        assign result    = res_d;
        assign illegal   = illegal_d;
        assign valid_out = valid_in;
    end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
    import simd_cmp_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int NARROW_W   = 16,
    parameter int WIDE_W     = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              valid_in,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              illegal,
    output logic              valid_out
);

    localparam int N_NARROW = DATA_W / NARROW_W;
    localparam int N_WIDE   = DATA_W / WIDE_W;

    cmp_ctrl_t           ctrl;
    logic [N_NARROW-1:0] gt_n, eq_n;
    logic [N_WIDE-1:0]   gt_w, eq_w;
    logic [DATA_W-1:0]   res_d;

    simd_cmp_decode u_dec (
        .en     (en),
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    simd_cmp_lanes #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_narrow (
        .opa (src_a),
        .opb (src_b),
        .gt  (gt_n),
        .eq  (eq_n)
    );

    simd_cmp_lanes #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_wide (
        .opa (src_a),
        .opb (src_b),
        .gt  (gt_w),
        .eq  (eq_w)
    );

    simd_cmp_pack #(.DATA_W(DATA_W), .N_NARROW(N_NARROW), .N_WIDE(N_WIDE)) u_pack (
        .ctrl (ctrl),
        .gt_n (gt_n),
        .eq_n (eq_n),
        .gt_w (gt_w),
        .eq_w (eq_w),
        .res  (res_d)
    );

    simd_cmp_out #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_out (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .res_d     (res_d),
        .illegal_d (~ctrl.legal),
        .result    (result),
        .illegal   (illegal),
        .valid_out (valid_out)
    );

endmodule

// File: rtl/simd_cmp_chk.sv
module simd_cmp_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              valid_in,
    input logic [8:0]        opcode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] result,
    input logic              illegal,
    input logic              valid_out
);

    // R3: nothing lands above the four narrow lanes
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        result[DATA_W-1:4] == '0);

    // R3: wide mode uses only two bits
    assert_wide_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode[2]) |=> (result[DATA_W-1:2] == '0));

    // R6: an illegal result is always zero
    assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0));

    // R7: disabled unit flags illegal
    assert_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !en) |=> (illegal && result == '0));

    // R8: one-cycle strobe latency
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R8: outputs hold without a strobe
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result) && $stable(illegal) && !valid_out));

    // R1: equal operands satisfy narrow equality in every lane
    assert_self_eq_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_in && en && opcode == 9'h02A && src_a == src_b) |=> (result[3:0] == 4'hF));

    // R2: equal operands satisfy wide equality in both lanes
    assert_self_eq_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_in && en && opcode == 9'h02E && src_a == src_b) |=> (result[1:0] == 2'b11));

    // R9: reset clears the outputs
    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (result == '0 && !illegal && !valid_out));

endmodule

bind simd_lane_cmp simd_cmp_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/simd_lane_cmp_tb.sv
`timescale 1ns/1ps
module simd_lane_cmp_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        valid_in;
    logic [8:0]  opcode;
    logic [63:0] src_a, src_b;
    logic [63:0] result;
    logic        illegal;
    logic        valid_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    simd_lane_cmp u_dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .valid_in  (valid_in),
        .opcode    (opcode),
        .src_a     (src_a),
        .src_b     (src_b),
        .result    (result),
        .illegal   (illegal),
        .valid_out (valid_out)
    );

    logic [15:0] pool [8];
    initial begin
        pool[0] = 16'h8000; pool[1] = 16'h8001; pool[2] = 16'hFFFF; pool[3] = 16'h0000;
        pool[4] = 16'h0001; pool[5] = 16'h7FFE; pool[6] = 16'h7FFF; pool[7] = 16'h0100;
    end

    // expected {illegal, result}, from the opcode table and lane rules
    function automatic logic [64:0] model(input logic [8:0] opc, input logic [63:0] a,
                                          input logic [63:0] b, input logic e);
        int  rel;
        bit  wide;
        bit  ok;
        logic [63:0] r;
        ok = 1; rel = 0; wide = 0; r = '0;
        case (opc)
            9'h020: begin rel = 2; wide = 0; end
            9'h022: begin rel = 3; wide = 0; end
            9'h024: begin rel = 2; wide = 1; end
            9'h026: begin rel = 3; wide = 1; end
            9'h028: begin rel = 0; wide = 0; end
            9'h02A: begin rel = 1; wide = 0; end
            9'h02C: begin rel = 0; wide = 1; end
            9'h02E: begin rel = 1; wide = 1; end
            default: ok = 0;
        endcase
        if (!e || !ok) return {1'b1, 64'd0};
        for (int k = 0; k < (wide ? 2 : 4); k++) begin
            longint sa, sb;
            bit hit;
            if (wide) begin
                sa = longint'($signed(a[k*32 +: 32]));
                sb = longint'($signed(b[k*32 +: 32]));
            end else begin
                sa = longint'($signed(a[k*16 +: 16]));
                sb = longint'($signed(b[k*16 +: 16]));
            end
            case (rel)
                0: hit = (sa > sb);
                1: hit = (sa == sb);
                2: hit = (sa <= sb);
                default: hit = (sa != sb);
            endcase
            r[k] = hit;
        end
        return {1'b0, r};
    endfunction

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, capture on the rising edge, sample at the next falling edge
    task automatic issue(input logic [8:0] opc, input logic [63:0] a, input logic [63:0] b,
                         input logic e);
        opcode = opc; src_a = a; src_b = b; en = e; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic issue_and_check(input logic [8:0] opc, input logic [63:0] a,
                                   input logic [63:0] b, input logic e);
        logic [64:0] exp;
        string tag;
        exp = model(opc, a, b, e);
        issue(opc, a, b, e);
        if (!e)             tag = "R7";
        else if (exp[64])   tag = "R6";
        else if (opc[2])    tag = "R2";
        else                tag = "R1";
        check(tag, {illegal, result}, exp);
        check("R3", {61'd0, (result[63:4] != 0) || (opc[2] && result[3:2] != 0)}, 65'd0);
        check("R8 valid_out", {64'd0, valid_out}, 65'd1);
    endtask

    function automatic logic [63:0] mk(input int p, input int s);
        logic [63:0] v;
        for (int k = 0; k < 4; k++) v[k*16 +: 16] = pool[(p + s*k + k*k) % 8];
        return v;
    endfunction

    initial begin
        rst = 1'b1; en = 1'b1; valid_in = 1'b0; opcode = '0; src_a = '0; src_b = '0;
        @(negedge clk); @(negedge clk);
        // R9: reset state
        check("R9 reset", {valid_out, illegal, result}, 66'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle", {valid_out, illegal, result}, 66'd0);

        // R5: every legal code on a pattern that separates all four relations
        begin
            logic [63:0] a, b;
            a = {16'hFFFE, 16'h0003, 16'h0007, 16'h0005};
            b = {16'h0001, 16'h0003, 16'hFFF9, 16'h0009};
            issue(9'h028, a, b, 1); check("R5 gt16", {illegal, result}, {1'b0, 64'h2});
            issue(9'h02A, a, b, 1); check("R5 eq16", {illegal, result}, {1'b0, 64'h4});
            issue(9'h020, a, b, 1); check("R5 le16", {illegal, result}, {1'b0, 64'hD});
            issue(9'h022, a, b, 1); check("R5 ne16", {illegal, result}, {1'b0, 64'hB});
            issue(9'h02C, a, b, 1); check("R5 gt32", {illegal, result}, {1'b0, 64'h1});
            issue(9'h02E, a, b, 1); check("R5 eq32", {illegal, result}, {1'b0, 64'h0});
            issue(9'h024, a, b, 1); check("R5 le32", {illegal, result}, {1'b0, 64'h2});
            issue(9'h026, a, b, 1); check("R5 ne32", {illegal, result}, {1'b0, 64'h3});
        end

        // R4: operand order
        issue(9'h028, 64'h1, 64'h0, 1); check("R4 a>b", {illegal, result}, {1'b0, 64'h1});
        issue(9'h028, 64'h0, 64'h1, 1); check("R4 a<b", {illegal, result}, {1'b0, 64'h0});
        issue(9'h02C, 64'h0000_0000_8000_0000, 64'h0, 1);
        check("R4 signed32", {illegal, result}, {1'b0, 64'h0});

        // R7: enable low with a legal code and equal operands
        issue(9'h02A, 64'h1234, 64'h1234, 0);
        check("R7 disabled", {illegal, result}, {1'b1, 64'h0});

        // R8: hold when no strobe
        issue(9'h02A, 64'h0, 64'h0, 1);
        opcode = 9'h1FF; src_a = 64'h5; src_b = 64'h6; en = 1'b0;
        @(negedge clk);
        check("R8 hold", {valid_out, illegal, result}, {1'b0, 1'b0, 64'hF});
        en = 1'b1;

        // R6, R1, R2, R3: the full code space over a rotating pool
        for (int op = 0; op < 512; op++) begin
            for (int p = 0; p < 8; p++) begin
                issue_and_check(op[8:0], mk(p, 1), mk(p + op, 3), 1'b1);
            end
        end

        // R1, R2: dense sweep of the legal codes over the signed extremes
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 256; p++) begin
                issue_and_check(9'h020 + 9'(2*c), mk(p, p / 8), mk(p / 3, p % 5), 1'b1);
            end
        end

        // R7: enable low across all legal codes
        for (int c = 0; c < 8; c++) begin
            issue_and_check(9'h020 + 9'(2*c), mk(c, 1), mk(c, 1), 1'b0);
        end

        // R9: reset after activity
        issue(9'h022, 64'h1, 64'h2, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset again", {valid_out, illegal, result}, 66'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule